// File: doc/BRIEF.md
# Annul-Aware Register Dependency Scoreboard

This block guards the issue point of an in-order pipeline whose instructions travel through the stages G, E, C, N1, N2 and N3 before a final write stage W that software does not normally see. Each accepted instruction that writes a register takes a scoreboard slot holding its destination and a count of the cycles left until it reaches W. A candidate instruction whose source operand names a register that some live slot still holds is stalled at issue.

Branch delay slots need special handling. An annulling branch predicted not taken still lets its delay-slot instruction enter the pipeline. If that instruction is not a load, it keeps its destination pending until it reaches W, so a divide in an annulled slot still holds back its readers. An annulled load is released at dispatch: it never takes a slot and never stalls anything. A separate multicycle-unit tracker holds a busy flag for the full latency of any accepted multicycle operation, annulled or not, and refuses a second such operation until the flag drops.

Each slot runs a small state machine with the states SLOT_IDLE, SLOT_LIVE (a normal pending write) and SLOT_GHOST (a pending write from an annulled delay slot). The transitions are claim (IDLE to LIVE or GHOST when the slot is chosen), tick (count down on each advancing cycle) and retire (LIVE or GHOST to IDLE when an advancing cycle finds the count at 1). The multicycle tracker has the states MC_IDLE and MC_RUN, with the transitions launch (IDLE to RUN on an accepted multicycle operation) and finish (RUN to IDLE when the count reaches 1, counted on every clock).

Top module: `annul_scoreboard`

## Requirements
- R1: While reset is low, and in the first cycle after it, `stall`, `pend_mask` and `mc_busy` are all zero.
- R2: `stall` is high in the same cycle that `iss_valid` is high and an enabled source operand other than register 0 names a register whose `pend_mask` bit is set. Register 0 and a source with its enable low never cause a stall.
- R3: An instruction is accepted when `iss_valid` and `adv` are high and `stall` is low. If it is accepted with `iss_dst_en` high and `iss_dst` not 0, and it is not an annulled load, its `pend_mask` bit is set from the next cycle for exactly `iss_lat` cycles in which `adv` is high. An `iss_lat` of 0 counts as 1.
- R4: An annulled delay-slot instruction (`iss_annul` high) whose class is not load keeps its destination pending for its full latency, the same as an instruction that is not annulled.
- R5: An accepted annulled load (`iss_annul` high, `iss_cls` = 2'b01) never sets a `pend_mask` bit and never stalls a later reader.
- R6: A load that is not annulled keeps its destination pending for its full latency.
- R7: While `stall` is high, the presented instruction is not entered, and the slots already in flight keep counting down on each cycle with `adv` high.
- R8: While `adv` is low, nothing is accepted and `pend_mask` holds its value.
- R9: An accepted multicycle operation (`iss_cls` = 2'b10) drives `mc_busy` high for exactly `iss_lat` clock cycles starting the next cycle, whatever its annul status. While `mc_busy` is high, a presented multicycle operation stalls.
- R10: When all slots are live, any presented instruction stalls.
- R11: An instruction with `iss_dst_en` low or `iss_dst` equal to 0 takes no slot and sets no `pend_mask` bit. Class 2'b00 is a single-cycle ALU operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Pipeline advance enable |
| iss_valid | input | 1 | Candidate instruction present |
| iss_cls | input | 2 | Class: 00 ALU, 01 load, 10 multicycle |
| iss_src1 | input | 5 | First source register |
| iss_src1_en | input | 1 | First source is used |
| iss_src2 | input | 5 | Second source register |
| iss_src2_en | input | 1 | Second source is used |
| iss_dst | input | 5 | Destination register |
| iss_dst_en | input | 1 | Instruction writes a register |
| iss_lat | input | 4 | Cycles until the write stage |
| iss_annul | input | 1 | Candidate is an annulled delay slot |
| stall | output | 1 | Hold the candidate at issue |
| pend_mask | output | 32 | One bit per pending destination register |
| mc_busy | output | 1 | Multicycle unit occupied |

## Verification
The bench targets an annulled divide followed by a reader of its result. A design that freed annulled slots early would let the reader through many cycles too soon. The reverse case is an annulled load followed by a reader: a design that entered the load anyway would stall the reader needlessly. The bench also drives reads of register 0 and of disabled operands, which a careless comparator would stall on. It freezes `adv` with writes in flight, which a design counting on every clock would let drain. It fills every slot to force the full-table stall, and it launches a second multicycle operation while the first is still busy, including the cycle where the busy count reaches 1.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        CLS_ALU   = 2'b00,
        CLS_LOAD  = 2'b01,
        CLS_MULTI = 2'b10
    } iclass_e;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'b00,
        SLOT_LIVE  = 2'b01,
        SLOT_GHOST = 2'b10
    } slot_state_e;

    typedef enum logic {
        MC_IDLE = 1'b0,
        MC_RUN  = 1'b1
    } mc_state_e;
endpackage

// File: rtl/sb_slot.sv
module sb_slot
    import sb_pkg::*;
#(
    parameter int RW   = 5,
    parameter int LATW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            claim,
    input  logic            claim_ghost,
    input  logic [RW-1:0]   claim_dst,
    input  logic [LATW-1:0] claim_lat,
    output logic            live,
    output logic [RW-1:0]   dst
);
    slot_state_e     state_q, state_d;
    logic [LATW-1:0] cnt_q, cnt_d;
    logic [RW-1:0]   dst_q, dst_d;

    // next state: claim, tick, retire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        dst_d   = dst_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (claim) begin
                    state_d = claim_ghost ? SLOT_GHOST : SLOT_LIVE;
                    cnt_d   = claim_lat;
                    dst_d   = claim_dst;
                end
            end
            SLOT_LIVE, SLOT_GHOST: begin
                if (adv) begin
                    if (cnt_q == LATW'(1)) state_d = SLOT_IDLE;
                    cnt_d = cnt_q - LATW'(1);
                end
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            cnt_q   <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dst_q   <= dst_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SLOT_LIVE, SLOT_GHOST: live = 1'b1;
            default:               live = 1'b0;
        endcase
        dst = dst_q;
    end
endmodule

// File: rtl/sb_mcu.sv
module sb_mcu
    import sb_pkg::*;
#(
    parameter int LATW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic [LATW-1:0] launch_lat,
    output logic            busy
);
    mc_state_e       state_q, state_d;
    logic [LATW-1:0] cnt_q, cnt_d;

    // next state: launch, finish
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            MC_IDLE: begin
                if (launch) begin
                    state_d = MC_RUN;
                    cnt_d   = launch_lat;
                end
            end
            MC_RUN: begin
                if (cnt_q == LATW'(1)) state_d = MC_IDLE;
                cnt_d = cnt_q - LATW'(1);
            end
            default: state_d = MC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            MC_RUN:  busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/annul_scoreboard.sv
module annul_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int DEPTH = 8,
    parameter int LATW  = 4,
    localparam int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            iss_valid,
    input  logic [1:0]      iss_cls,
    input  logic [RW-1:0]   iss_src1,
    input  logic            iss_src1_en,
    input  logic [RW-1:0]   iss_src2,
    input  logic            iss_src2_en,
    input  logic [RW-1:0]   iss_dst,
    input  logic            iss_dst_en,
    input  logic [LATW-1:0] iss_lat,
    input  logic            iss_annul,
    output logic            stall,
    output logic [NREG-1:0] pend_mask,
    output logic            mc_busy
);
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] claim;
    logic [RW-1:0]    sdst [DEPTH];
    logic             hit1, hit2, full, mc_clash, accept, want_slot, taken;
    logic [LATW-1:0]  eff_lat;

    always_comb begin
        pend_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i]) pend_mask = pend_mask | (NREG'(1) << sdst[i]);
        end
    end

    assign hit1     = iss_src1_en && (iss_src1 != '0) && pend_mask[iss_src1];
    assign hit2     = iss_src2_en && (iss_src2 != '0) && pend_mask[iss_src2];
    assign full     = &live;
    assign mc_clash = (iss_cls == CLS_MULTI) && mc_busy;
    assign stall    = iss_valid && (hit1 || hit2 || full || mc_clash);
    assign accept   = iss_valid && adv && !stall;
    assign eff_lat  = (iss_lat == '0) ? LATW'(1) : iss_lat;
    assign want_slot = accept && iss_dst_en && (iss_dst != '0)
                       && !(iss_annul && (iss_cls == CLS_LOAD));

    always_comb begin
        claim = '0;
        taken = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (want_slot && !live[i] && !taken) begin
                claim[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sb_slot #(.RW(RW), .LATW(LATW)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .adv         (adv),
            .claim       (claim[g]),
            .claim_ghost (iss_annul),
            .claim_dst   (iss_dst),
            .claim_lat   (eff_lat),
            .live        (live[g]),
            .dst         (sdst[g])
        );
    end

    sb_mcu #(.LATW(LATW)) u_mcu (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (accept && (iss_cls == CLS_MULTI)),
        .launch_lat (eff_lat),
        .busy       (mc_busy)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            adv,
    input logic            iss_valid,
    input logic [1:0]      iss_cls,
    input logic [RW-1:0]   iss_src1,
    input logic            iss_src1_en,
    input logic [RW-1:0]   iss_dst,
    input logic            iss_dst_en,
    input logic            iss_annul,
    input logic            stall,
    input logic [NREG-1:0] pend_mask,
    input logic            mc_busy
);
    logic acc;
    assign acc = iss_valid && adv && !stall;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_mask == '0 && !mc_busy));

    assert_src_hit_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_src1_en && iss_src1 != '0 && pend_mask[iss_src1]) |-> stall);

    assert_write_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && iss_dst_en && iss_dst != '0 && !(iss_annul && iss_cls == 2'b01))
        |=> pend_mask[$past(iss_dst)]);

    assert_annul_load_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && iss_annul && iss_cls == 2'b01 && !pend_mask[iss_dst])
        |=> !pend_mask[$past(iss_dst)]);

    assert_frozen_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pend_mask));

    assert_mc_launch_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && iss_cls == 2'b10) |=> mc_busy);
endmodule

bind annul_scoreboard sb_checker #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .adv(adv), .iss_valid(iss_valid),
    .iss_cls(iss_cls), .iss_src1(iss_src1), .iss_src1_en(iss_src1_en),
    .iss_dst(iss_dst), .iss_dst_en(iss_dst_en), .iss_annul(iss_annul),
    .stall(stall), .pend_mask(pend_mask), .mc_busy(mc_busy)
);

// File: tb/sim_annul_scoreboard.sv
`timescale 1ns/1ps
module sim_annul_scoreboard;
    localparam int NREG = 32, DEPTH = 8, LATW = 4, RW = 5;

    logic clk = 1'b0, rst_n = 1'b0, adv = 1'b1;
    logic iss_valid = 1'b0, iss_src1_en = 1'b0, iss_src2_en = 1'b0;
    logic iss_dst_en = 1'b0, iss_annul = 1'b0;
    logic [1:0] iss_cls = 2'b00;
    logic [RW-1:0] iss_src1 = '0, iss_src2 = '0, iss_dst = '0;
    logic [LATW-1:0] iss_lat = '0;
    logic stall, mc_busy;
    logic [NREG-1:0] pend_mask;

    always #2.5 clk = ~clk;

    annul_scoreboard #(.NREG(NREG), .DEPTH(DEPTH), .LATW(LATW)) u0 (.*);

    typedef struct { int dst; int rem; } ent_t;
    ent_t q[$];
    int mb = 0;
    int checks = 0, fails = 0;
    string tag = "R1";
    bit last_acc;

    function automatic bit pend(int r);
        foreach (q[i]) if (q[i].dst == r) return 1'b1;
        return 1'b0;
    endfunction

    task automatic tick();
        bit es; logic [NREG-1:0] em; int lat;
        #1;
        em = '0;
        foreach (q[i]) em[q[i].dst] = 1'b1;
        es = iss_valid && ((iss_src1_en && iss_src1 != 0 && pend(int'(iss_src1))) ||
                           (iss_src2_en && iss_src2 != 0 && pend(int'(iss_src2))) ||
                           (iss_cls == 2'b10 && mb > 0) || q.size() == DEPTH);
        checks++;
        if (stall !== es || pend_mask !== em || mc_busy !== (mb > 0)) begin
            fails++;
            $display("FAIL %s stall=%b/%b mask=%h/%h busy=%b/%b", tag,
                     stall, es, pend_mask, em, mc_busy, mb > 0);
        end
        last_acc = iss_valid && adv && !es;
        lat = (iss_lat == 0) ? 1 : int'(iss_lat);
        @(posedge clk);
        if (adv) begin
            for (int i = q.size() - 1; i >= 0; i--) begin
                q[i].rem--;
                if (q[i].rem == 0) q.delete(i);
            end
        end
        if (mb > 0) mb--;
        if (last_acc) begin
            if (iss_cls == 2'b10) mb = lat;
            if (iss_dst_en && iss_dst != 0 && !(iss_annul && iss_cls == 2'b01))
                q.push_back('{int'(iss_dst), lat});
        end
        @(negedge clk);
    endtask

    task automatic put(bit v, int cls, int s1, bit e1, int s2, bit e2,
                       int d, bit de, int lat, bit an);
        iss_valid = v; iss_cls = cls[1:0];
        iss_src1 = s1[RW-1:0]; iss_src1_en = e1;
        iss_src2 = s2[RW-1:0]; iss_src2_en = e2;
        iss_dst = d[RW-1:0]; iss_dst_en = de;
        iss_lat = lat[LATW-1:0]; iss_annul = an;
    endtask

    task automatic idle(int n);
        put(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < n; i++) tick();
    endtask

    // present until accepted
    task automatic issue(int cls, int s1, bit e1, int d, int lat, bit an);
        put(1, cls, s1, e1, 0, 0, d, 1, lat, an);
        for (int i = 0; i < 40; i++) begin
            tick();
            if (last_acc) break;
        end
        put(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        checks++;
        if (stall !== 1'b0 || pend_mask !== '0 || mc_busy !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset stall=%b mask=%h busy=%b exp 0/0/0", stall, pend_mask, mc_busy);
        end
        rst_n = 1'b1;
        tag = "R1"; idle(2);

        tag = "R3_R2_R7 alu write then reader";
        issue(0, 0, 0, 5, 3, 0);
        issue(0, 5, 1, 6, 1, 0);
        idle(3);

        tag = "R11_R2 r0 and disabled sources";
        issue(0, 0, 0, 0, 4, 0);
        put(0, 0, 0, 0, 0, 0, 9, 0, 4, 0);
        put(1, 0, 0, 1, 0, 1, 9, 0, 4, 0); tick();
        issue(0, 0, 0, 7, 4, 0);
        put(1, 0, 7, 0, 0, 1, 8, 1, 1, 0); tick();
        idle(5);

        tag = "R4_R9 annulled divide holds reader";
        issue(2, 0, 0, 1, 12, 1);
        issue(0, 1, 1, 2, 1, 0);
        idle(3);

        tag = "R5 annulled load released at dispatch";
        issue(1, 0, 0, 2, 3, 1);
        issue(0, 2, 1, 3, 1, 0);
        idle(2);

        tag = "R6 plain load holds reader";
        issue(1, 0, 0, 2, 3, 0);
        issue(0, 2, 1, 3, 1, 0);
        idle(3);

        tag = "R8 advance frozen";
        issue(0, 0, 0, 4, 2, 0);
        adv = 1'b0;
        put(1, 0, 4, 1, 0, 0, 5, 1, 1, 0);
        for (int i = 0; i < 4; i++) tick();
        adv = 1'b1;
        idle(4);

        tag = "R9 second multicycle op";
        issue(2, 0, 0, 10, 5, 0);
        issue(2, 0, 0, 11, 3, 1);
        idle(6);

        tag = "R10 table full";
        for (int i = 1; i <= DEPTH + 1; i++) issue(0, 0, 0, i + 12, 15, 0);
        idle(16);

        tag = "MIX R2 R3 R5 R7 R8 R9 R10";
        for (int n = 0; n < 3000; n++) begin
            adv = ($urandom_range(0, 9) != 0);
            put($urandom_range(0, 3) != 0, $urandom_range(0, 2),
                $urandom_range(0, 7), $urandom_range(0, 1),
                $urandom_range(0, 7), $urandom_range(0, 1),
                $urandom_range(0, 7), $urandom_range(0, 3) != 0,
                $urandom_range(0, 7), $urandom_range(0, 2) == 0);
            tick();
        end
        adv = 1'b1;
        idle(20);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule